// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block produces the external memory bus timing for an 8-bit controller whose low address byte and data byte share one set of pins. Time is divided into machine cycles of twelve oscillator ticks, which are six states of two phases each. Each half of a machine cycle is a slot. In a slot the block drives the low address with an address-latch strobe, then optionally runs a code read strobe. An external data machine cycle replaces both slots with one read or write transfer.

The core presents a code-fetch enable and program counter at every slot boundary. It presents a data request, direction, address width select, data pointer, write byte and port-2 register value at every machine cycle boundary. The block returns the fetched instruction byte and the read data byte, each with a one-tick valid pulse. Two boundary outputs tell the core when its requests are sampled.

Top module: `ext_bus_seq`

## Requirements
- R1: A machine cycle lasts 12 ticks, numbered 0 to 11. In a code cycle `ale_o` is high in ticks 0, 1, 6 and 7 and low in every other tick. This gives one pulse every 6 ticks.
- R2: In ticks 0 to 2 of a code slot, `ad_oe_o` is 1 and `ad_o` carries the low byte of the slot's program counter. The address therefore stays valid for one tick after `ale_o` falls.
- R3: In a code slot with fetch enabled, `psen_n_o` is 0 in slot ticks 3 to 5. In a slot with fetch disabled it stays 1. `ad_oe_o` is 0 in slot ticks 3 to 5.
- R4: The bus value present in the last low tick of `psen_n_o` appears on `instr_o`. `instr_vld_o` is 1 for exactly the following tick, which is the tick in which `psen_n_o` returns high.
- R5: In a data cycle, `ale_o` pulses only in ticks 0 and 1, so the pulse at tick 6 is omitted. `psen_n_o` stays 1 for all 12 ticks.
- R6: In a read cycle, `rd_n_o` is 0 in ticks 3 to 9 and `ad_oe_o` is 0 in ticks 3 to 11. The bus value of tick 9 appears on `rdata_o`, with `rdata_vld_o` equal to 1 in tick 10 only.
- R7: In a write cycle, `wr_n_o` is 0 in ticks 3 to 9. `ad_o` carries the write byte with `ad_oe_o` equal to 1 in ticks 3 to 10. In ticks 0 to 2 it carries the low byte of the data pointer.
- R8: During the 12 ticks of a data cycle, `ahi_o` equals the pointer high byte when `data_wide_i` was 1. It equals the captured `p2_i` value when `data_wide_i` was 0.
- R9: Outside data cycles, `ahi_o` equals the program counter high byte sampled for the current slot. This includes the cycle right after a data cycle.
- R10: `slot_end_o` is 1 in ticks 5 and 11, and `mcyc_end_o` is 1 in tick 11. Fetch inputs are taken at the clock edges that end ticks 5 and 11. Data inputs are taken only at the edge that ends tick 11. A fetch enable presented for a data cycle has no effect.
- R11: While `rst_ni` is 0, the outputs are as follows: `ale_o`=0, `psen_n_o`=`rd_n_o`=`wr_n_o`=1, `ad_oe_o`=0 and both valid outputs 0. The first clock edge after release starts tick 0.
- R12: `rd_n_o` and `wr_n_o` are never both 0. Neither is 0 while `psen_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one tick per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_en_i | input | 1 | Run a code read in the next slot |
| pc_i | input | 16 | Program counter for the next slot |
| data_req_i | input | 1 | Next machine cycle is a data transfer |
| data_we_i | input | 1 | 1 = write, 0 = read |
| data_wide_i | input | 1 | 1 = 16-bit pointer, 0 = 8-bit with port-2 high byte |
| data_addr_i | input | 16 | Data pointer |
| wdata_i | input | 8 | Write byte |
| p2_i | input | 8 | Port-2 register value |
| ad_i | input | 8 | Multiplexed bus input |
| ad_o | output | 8 | Multiplexed bus output value |
| ad_oe_o | output | 1 | Multiplexed bus output enable |
| ahi_o | output | 8 | High address lines |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Code read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| instr_o | output | 8 | Captured instruction byte |
| instr_vld_o | output | 1 | Instruction byte valid pulse |
| rdata_o | output | 8 | Captured read byte |
| rdata_vld_o | output | 1 | Read byte valid pulse |
| slot_end_o | output | 1 | Fetch inputs sampled at the next edge |
| mcyc_end_o | output | 1 | Data inputs sampled at the next edge |

## Verification
A wrong tick count or slot phase moves `ale_o` off its 6-tick grid. This is visible within one slot, and the boundary outputs drift against the bench's own count. A wrong latched cycle kind appears in the same machine cycle in one of two ways. Either a stray or missing pulse on `psen_n_o`, `rd_n_o` or `wr_n_o`, or a missing ALE pulse at tick 6. A wrong high-byte source shows on `ahi_o` from tick 0 of the data cycle. A capture taken at the wrong edge returns a bus byte that differs from the one driven in the strobe's last tick, and this is reported at the following valid pulse.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    CYC_CODE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/ebs_timebase.sv
module ebs_timebase #(
  parameter int TICKS = 12,
  parameter int HALF  = 6,
  parameter int TW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [TW-1:0] tick_o,
  output logic [TW-1:0] hph_o,
  output logic          slot_end_o,
  output logic          mcyc_end_o
);
  logic [TW-1:0] tick_q;

  // reset parks on the last tick so the first edge opens tick 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tick_q <= TW'(TICKS - 1);
    else if (tick_q == TW'(TICKS - 1))  tick_q <= '0;
    else                                tick_q <= tick_q + TW'(1);
  end

  always_comb begin
    tick_o     = tick_q;
    hph_o      = (tick_q >= TW'(HALF)) ? tick_q - TW'(HALF) : tick_q;
    mcyc_end_o = (tick_q == TW'(TICKS - 1));
    slot_end_o = mcyc_end_o || (tick_q == TW'(HALF - 1));
  end
endmodule

// File: rtl/ebs_req_latch.sv
module ebs_req_latch
  import ebs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int HW = AW - DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slot_end_i,
  input  logic          mcyc_end_i,
  input  logic          fetch_en_i,
  input  logic [AW-1:0] pc_i,
  input  logic          data_req_i,
  input  logic          data_we_i,
  input  logic          data_wide_i,
  input  logic [AW-1:0] data_addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [HW-1:0] p2_i,
  output cyc_e          kind_o,
  output logic          wide_o,
  output logic [AW-1:0] daddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [HW-1:0] p2_o,
  output logic [AW-1:0] pc_o,
  output logic          fen_o
);
  cyc_e          kind_q;
  logic          wide_q, fen_q;
  logic [AW-1:0] daddr_q, pc_q;
  logic [DW-1:0] wdata_q;
  logic [HW-1:0] p2_q;
  logic          next_is_data;

  // kind that governs the slot being opened
  assign next_is_data = mcyc_end_i ? data_req_i : (kind_q != CYC_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= CYC_CODE;
      wide_q  <= 1'b0;
      daddr_q <= '0;
      wdata_q <= '0;
      p2_q    <= '0;
    end else if (mcyc_end_i) begin
      kind_q  <= !data_req_i ? CYC_CODE : (data_we_i ? CYC_WRITE : CYC_READ);
      wide_q  <= data_wide_i;
      daddr_q <= data_addr_i;
      wdata_q <= wdata_i;
      p2_q    <= p2_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      fen_q <= 1'b0;
    end else if (slot_end_i) begin
      pc_q  <= pc_i;
      fen_q <= fetch_en_i && !next_is_data;
    end
  end

  assign kind_o  = kind_q;
  assign wide_o  = wide_q;
  assign daddr_o = daddr_q;
  assign wdata_o = wdata_q;
  assign p2_o    = p2_q;
  assign pc_o    = pc_q;
  assign fen_o   = fen_q;
endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen
  import ebs_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int HW       = AW - DW,
  parameter int TW       = 4,
  parameter int HALF     = 6,
  parameter int ALE_END  = 2,
  parameter int STB_BEG  = 3,
  parameter int DSTB_END = 9,
  parameter int WDAT_END = 10
) (
  input  logic [TW-1:0] tick_i,
  input  logic [TW-1:0] hph_i,
  input  cyc_e          kind_i,
  input  logic          wide_i,
  input  logic [AW-1:0] daddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [HW-1:0] p2_i,
  input  logic [AW-1:0] pc_i,
  input  logic          fen_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          ad_oe_o,
  output logic [DW-1:0] ad_o,
  output logic [HW-1:0] ahi_o,
  output logic          cap_instr_o,
  output logic          cap_rdata_o
);
  logic in_dstb;

  assign in_dstb = (tick_i >= TW'(STB_BEG)) && (tick_i <= TW'(DSTB_END));

  always_comb begin
    ale_o       = 1'b0;
    psen_n_o    = 1'b1;
    rd_n_o      = 1'b1;
    wr_n_o      = 1'b1;
    ad_oe_o     = 1'b0;
    ad_o        = pc_i[DW-1:0];
    ahi_o       = pc_i[AW-1:DW];
    cap_instr_o = 1'b0;
    cap_rdata_o = 1'b0;
    unique case (kind_i)
      CYC_CODE: begin
        ale_o       = hph_i < TW'(ALE_END);
        ad_oe_o     = hph_i < TW'(STB_BEG);
        psen_n_o    = !(fen_i && (hph_i >= TW'(STB_BEG)));
        cap_instr_o = fen_i && (hph_i == TW'(HALF - 1));
      end
      CYC_READ, CYC_WRITE: begin
        ahi_o  = wide_i ? daddr_i[AW-1:DW] : p2_i;
        ale_o  = tick_i < TW'(ALE_END);
        rd_n_o = !((kind_i == CYC_READ) && in_dstb);
        wr_n_o = !((kind_i == CYC_WRITE) && in_dstb);
        if (tick_i < TW'(STB_BEG)) begin
          ad_oe_o = 1'b1;
          ad_o    = daddr_i[DW-1:0];
        end else if ((kind_i == CYC_WRITE) && (tick_i <= TW'(WDAT_END))) begin
          ad_oe_o = 1'b1;
          ad_o    = wdata_i;
        end
        cap_rdata_o = (kind_i == CYC_READ) && (tick_i == TW'(DSTB_END));
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ebs_capture.sv
module ebs_capture #(
  parameter int DW    = 8,
  parameter int LANES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [LANES-1:0]           cap_i,
  input  logic [DW-1:0]              ad_i,
  output logic [LANES-1:0][DW-1:0]   data_o,
  output logic [LANES-1:0]           vld_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] data_q;
    logic          vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= cap_i[g];
        if (cap_i[g]) data_q <= ad_i;
      end
    end
    assign data_o[g] = data_q;
    assign vld_o[g]  = vld_q;
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int STATES = 6,
  parameter int PHASES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_en_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              data_req_i,
  input  logic              data_we_i,
  input  logic              data_wide_i,
  input  logic [AW-1:0]     data_addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [AW-DW-1:0]  p2_i,
  input  logic [DW-1:0]     ad_i,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  output logic [AW-DW-1:0]  ahi_o,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DW-1:0]     instr_o,
  output logic              instr_vld_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rdata_vld_o,
  output logic              slot_end_o,
  output logic              mcyc_end_o
);
  localparam int TICKS    = STATES * PHASES;
  localparam int HALF     = TICKS / 2;
  localparam int TW       = $clog2(TICKS);
  localparam int HW       = AW - DW;
  localparam int ALE_END  = PHASES;
  localparam int STB_BEG  = PHASES + 1;
  localparam int DSTB_END = TICKS - PHASES - 1;
  localparam int WDAT_END = TICKS - PHASES;
  localparam int LANES    = 2;

  logic [TW-1:0] tick, hph;
  cyc_e          kind;
  logic          wide, fen, cap_instr, cap_rdata;
  logic [AW-1:0] daddr, pc;
  logic [DW-1:0] wdata;
  logic [HW-1:0] p2;
  logic [LANES-1:0][DW-1:0] cap_data;
  logic [LANES-1:0]         cap_vld;

  ebs_timebase #(.TICKS(TICKS), .HALF(HALF), .TW(TW)) u_tb (
    .clk_i, .rst_ni, .tick_o(tick), .hph_o(hph),
    .slot_end_o, .mcyc_end_o
  );

  ebs_req_latch #(.AW(AW), .DW(DW), .HW(HW)) u_req (
    .clk_i, .rst_ni,
    .slot_end_i(slot_end_o), .mcyc_end_i(mcyc_end_o),
    .fetch_en_i, .pc_i, .data_req_i, .data_we_i, .data_wide_i,
    .data_addr_i, .wdata_i, .p2_i,
    .kind_o(kind), .wide_o(wide), .daddr_o(daddr), .wdata_o(wdata),
    .p2_o(p2), .pc_o(pc), .fen_o(fen)
  );

  ebs_strobe_gen #(
    .AW(AW), .DW(DW), .HW(HW), .TW(TW), .HALF(HALF), .ALE_END(ALE_END),
    .STB_BEG(STB_BEG), .DSTB_END(DSTB_END), .WDAT_END(WDAT_END)
  ) u_stb (
    .tick_i(tick), .hph_i(hph), .kind_i(kind), .wide_i(wide),
    .daddr_i(daddr), .wdata_i(wdata), .p2_i(p2), .pc_i(pc), .fen_i(fen),
    .ale_o, .psen_n_o, .rd_n_o, .wr_n_o, .ad_oe_o, .ad_o, .ahi_o,
    .cap_instr_o(cap_instr), .cap_rdata_o(cap_rdata)
  );

  ebs_capture #(.DW(DW), .LANES(LANES)) u_cap (
    .clk_i, .rst_ni, .cap_i({cap_rdata, cap_instr}), .ad_i,
    .data_o(cap_data), .vld_o(cap_vld)
  );

  assign instr_o     = cap_data[0];
  assign instr_vld_o = cap_vld[0];
  assign rdata_o     = cap_data[1];
  assign rdata_vld_o = cap_vld[1];
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int DW = 8,
  parameter int HW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ale_o,
  input logic          psen_n_o,
  input logic          rd_n_o,
  input logic          wr_n_o,
  input logic          ad_oe_o,
  input logic [DW-1:0] ad_o,
  input logic [HW-1:0] ahi_o,
  input logic          instr_vld_o,
  input logic          rdata_vld_o
);
  a_r12_rd_wr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  a_r12_no_data_strobe_in_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_n_o |-> (rd_n_o && wr_n_o));
  a_r3_bus_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_n_o || !rd_n_o) |-> !ad_oe_o);
  a_r2_addr_held_at_ale_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (ad_oe_o && $stable(ad_o)));
  a_r5_ale_not_with_psen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> psen_n_o);
  a_r4_instr_at_psen_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_vld_o |-> $rose(psen_n_o));
  a_r6_rdata_at_rd_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |-> $rose(rd_n_o));
  a_r7_write_drives_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> ad_oe_o);
  a_r8_ahi_steady_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o && $past(!rd_n_o)) |-> $stable(ahi_o));
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.DW(DW), .HW(AW - DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ale_o(ale_o), .psen_n_o(psen_n_o),
  .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .ad_oe_o(ad_oe_o), .ad_o(ad_o),
  .ahi_o(ahi_o), .instr_vld_o(instr_vld_o), .rdata_vld_o(rdata_vld_o)
);

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        fetch_en_i, data_req_i, data_we_i, data_wide_i;
  logic [15:0] pc_i, data_addr_i;
  logic [7:0]  wdata_i, p2_i, ad_i;
  logic [7:0]  ad_o, ahi_o, instr_o, rdata_o;
  logic        ad_oe_o, ale_o, psen_n_o, rd_n_o, wr_n_o;
  logic        instr_vld_o, rdata_vld_o, slot_end_o, mcyc_end_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  int          m_t;
  bit          m_data, m_we, m_wide, m_fen, p_instr, p_rdata;
  logic [15:0] m_daddr, m_pc;
  logic [7:0]  m_wd, m_p2, e_instr, e_rdata;
  int          mc;

  always #4 clk_i = ~clk_i;

  ext_bus_seq u_ext_bus_seq (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s tick=%0d act=%0h exp=%0h", tag, m_t, act, exp);
    end
  endtask

  task automatic check_tick();
    int h;
    h = m_t % 6;
    chk("R10 slot_end", 32'(slot_end_o), 32'(m_t == 5 || m_t == 11));
    chk("R10 mcyc_end", 32'(mcyc_end_o), 32'(m_t == 11));
    chk("R12 exclusive strobes", 32'((!rd_n_o && !wr_n_o) || (!psen_n_o && !(rd_n_o && wr_n_o))), 0);
    if (m_data) begin
      chk("R5 ale data", 32'(ale_o), 32'(m_t < 2));
      chk("R5/R10 psen data", 32'(psen_n_o), 1);
      chk("R6 rd", 32'(rd_n_o), 32'(!(!m_we && m_t >= 3 && m_t <= 9)));
      chk("R7 wr", 32'(wr_n_o), 32'(!(m_we && m_t >= 3 && m_t <= 9)));
      chk("R6/R7 oe", 32'(ad_oe_o), 32'(m_t < 3 || (m_we && m_t <= 10)));
      if (m_t < 3)       chk("R7 data addr", 32'(ad_o), 32'(m_daddr[7:0]));
      else if (ad_oe_o)  chk("R7 wdata", 32'(ad_o), 32'(m_wd));
      chk("R8 ahi", 32'(ahi_o), 32'(m_wide ? m_daddr[15:8] : m_p2));
    end else begin
      chk("R1 ale", 32'(ale_o), 32'(h < 2));
      chk("R3 psen", 32'(psen_n_o), 32'(!(m_fen && h >= 3)));
      chk("R12 rd idle", 32'(rd_n_o), 1);
      chk("R12 wr idle", 32'(wr_n_o), 1);
      chk("R2/R3 oe", 32'(ad_oe_o), 32'(h < 3));
      if (h < 3) chk("R2 addr", 32'(ad_o), 32'(m_pc[7:0]));
      chk("R9 ahi", 32'(ahi_o), 32'(m_pc[15:8]));
    end
    chk("R4 instr_vld", 32'(instr_vld_o), 32'(p_instr));
    if (p_instr) chk("R4 instr", 32'(instr_o), 32'(e_instr));
    chk("R6 rdata_vld", 32'(rdata_vld_o), 32'(p_rdata));
    if (p_rdata) chk("R6 rdata", 32'(rdata_o), 32'(e_rdata));
  endtask

  task automatic drive();
    ad_i = 8'($urandom);
    if (m_t == 5 || m_t == 11) begin
      fetch_en_i = ($urandom % 5) != 0;
      pc_i       = 16'($urandom);
    end
    if (m_t == 11) begin
      data_addr_i = 16'($urandom);
      wdata_i     = 8'($urandom);
      p2_i        = 8'($urandom);
      data_we_i   = $urandom % 2;
      data_wide_i = $urandom % 2;
      data_req_i  = ($urandom % 10) < 3;
      case (mc)  // directed opening sequence
        0: begin data_req_i = 0; fetch_en_i = 1; end
        1: begin data_req_i = 1; data_we_i = 0; data_wide_i = 0; fetch_en_i = 1; end // R10 fetch ignored
        2: begin data_req_i = 1; data_we_i = 1; data_wide_i = 1; end
        3: begin data_req_i = 1; data_we_i = 0; data_wide_i = 1; end
        4: begin data_req_i = 1; data_we_i = 1; data_wide_i = 0; end
        5: begin data_req_i = 0; fetch_en_i = 0; end
        6: begin data_req_i = 0; fetch_en_i = 1; end
        default: ;
      endcase
      mc++;
    end
  endtask

  task automatic step();
    p_instr = 0;
    p_rdata = 0;
    if ((m_t == 5 || m_t == 11) && !m_data && m_fen) begin p_instr = 1; e_instr = ad_i; end
    if (m_t == 9 && m_data && !m_we) begin p_rdata = 1; e_rdata = ad_i; end
    if (m_t == 11) begin
      m_data = data_req_i; m_we = data_we_i; m_wide = data_wide_i;
      m_daddr = data_addr_i; m_wd = wdata_i; m_p2 = p2_i;
    end
    if (m_t == 5 || m_t == 11) begin
      m_pc  = pc_i;
      m_fen = fetch_en_i && !m_data;
    end
    m_t = (m_t + 1) % 12;
  endtask

  initial begin
    void'($urandom(32'd7151));
    rst_ni = 0; fetch_en_i = 0; data_req_i = 0; data_we_i = 0; data_wide_i = 0;
    pc_i = '0; data_addr_i = '0; wdata_i = '0; p2_i = '0; ad_i = '0;
    m_t = 11; m_data = 0; m_we = 0; m_wide = 0; m_fen = 0; p_instr = 0; p_rdata = 0;
    m_daddr = '0; m_pc = '0; m_wd = '0; m_p2 = '0; e_instr = '0; e_rdata = '0; mc = 0;
    repeat (3) @(negedge clk_i);
    chk("R11 ale reset", 32'(ale_o), 0);
    chk("R11 strobes reset", 32'({psen_n_o, rd_n_o, wr_n_o}), 7);
    chk("R11 oe reset", 32'(ad_oe_o), 0);
    chk("R11 vld reset", 32'({instr_vld_o, rdata_vld_o}), 0);
    rst_ni = 1;
    for (int n = 0; n < 24000; n++) begin
      if (n > 0) @(negedge clk_i);
      check_tick();
      drive();
      step();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule